// File: doc/BRIEF.md
# Flash Lock-Bit Command Controller

This block is the lock-protection part of a byte-wide NOR flash command interface. A host issues bus write cycles that carry command bytes; a read returns either array data (modelled here as all ones) or the status byte, depending on the current read mode. The block keeps one lock flag per erase block and one master lock flag. It runs three lock operations: set one block lock, set the master lock, and clear every block lock at once. It also checks block erase and byte write requests against the lock state.

Two qualifier inputs shape every decision. One reports that the programming voltage is in range. The other reports that the reset pin is held at its high-voltage level, and this acts as an override of the locks. Every accepted operation runs through a fixed busy period. Any failure is posted into the status byte when that period ends. The causes of a failure can be told apart by which status bits are set.

Top module: `flk_lock_ctrl`

## Requirements
- R1: After reset all block locks and the master lock are 0, the block is in array read mode (`rd_data` = 8'hFF) and `rdy` is 1.
- R2: Command 8'h70 selects status read mode. Every other accepted command except 8'hFF also leaves the block in status mode, and 8'hFF returns it to array mode. In status mode `rd_data` is the status byte. Bit 7 of that byte is the ready flag, bits 5, 4, 3 and 1 are error flags, and bits 6, 2 and 0 read 0.
- R3: After the confirm write of any operation, whether it succeeds or fails, `rdy` and status bit 7 are 0 for exactly BUSY_CYC cycles and then return to 1.
- R4: Setup 8'h60 followed by confirm 8'hD0 clears every block lock in a single operation.
- R5: A confirm byte that does not fit its setup, or an unknown first command byte, sets status bits 4 and 5, leaves the locks unchanged and starts no busy period. Lock setup (8'h60) accepts 8'h01, 8'hF1 and 8'hD0. Erase setup (8'h20) accepts only 8'hD0. Write setup (8'h40) takes any byte as data.
- R6: When `vpp_ok` is 0 at confirm, the operation fails with status bit 3 set, and the locks stay unchanged. Clear and erase also set bit 5. Set-lock and byte write also set bit 4.
- R7: When the master lock is set and `rp_hh` is 0, a clear fails with bits 1 and 5 set and the locks unchanged. With `rp_hh` at 1, or with the master lock clear, the clear succeeds.
- R8: Setting a block lock (8'h60, 8'h01 at address `wr_blk`) succeeds unless the master lock is set and `rp_hh` is 0. In that case it fails with bits 1 and 4 set.
- R9: Setting the master lock (8'h60, 8'hF1) succeeds only with `rp_hh` at 1. Otherwise it fails with bits 1 and 4 set.
- R10: Block erase (8'h20, 8'hD0) and byte write (8'h40, data) to a locked block fail unless `rp_hh` is 1. A failed erase sets bits 1 and 5, and a failed write sets bits 1 and 4.
- R11: Once the master lock is set it stays set, including through a successful clear.
- R12: Error bits 1, 3, 4 and 5 stay set until command 8'h50 is written, and that command clears all four.
- R13: Writes accepted while `rdy` is 0 are ignored. They change neither locks, status nor mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_blk | input | BLK_W | Target block of the write |
| wr_data | input | 8 | Command or data byte |
| vpp_ok | input | 1 | Programming voltage in range |
| rp_hh | input | 1 | Reset pin at high voltage (lock override) |
| rd_data | output | 8 | Read data: status byte or 8'hFF |
| rdy | output | 1 | Ready, mirrors status bit 7 |
| blk_lock | output | NUM_BLK | Block lock flags |
| mst_lock | output | 1 | Master lock flag |

## Verification
Some properties are checked by assertions on every cycle. The master lock never falls. The locks move only on an operation's completion, and a clear leaves them all zero. The busy timer reloads to its full length and is never restarted while running. An invalid sequence never starts a busy period, and the error bits stay set unless the clear-status command arrives. Other behaviour can only be shown by the bench's scenarios. That covers the exact status byte for each failure cause, the priority of the voltage fault over the lock fault, the override through `rp_hh`, the length of the busy window as seen at `rdy`, and the read-mode switching.

// File: rtl/flk_pkg.sv
// Shared encodings for the lock-bit command controller.
// Assumes byte-wide commands; status bit positions are fixed by the bus protocol.
package flk_pkg;
    typedef enum logic [2:0] {
        OP_NONE, OP_SET_BLK, OP_SET_MST, OP_CLR_ALL, OP_ERASE, OP_WRITE
    } op_e;

    typedef enum logic [2:0] {
        MD_ARRAY, MD_STATUS, MD_LOCK_SU, MD_ERASE_SU, MD_WRITE_SU
    } mode_e;

    localparam logic [7:0] CMD_RD_ARRAY = 8'hFF;
    localparam logic [7:0] CMD_RD_STAT  = 8'h70;
    localparam logic [7:0] CMD_CLR_STAT = 8'h50;
    localparam logic [7:0] CMD_LOCK_SU  = 8'h60;
    localparam logic [7:0] CMD_ERASE_SU = 8'h20;
    localparam logic [7:0] CMD_WRITE_SU = 8'h40;
    localparam logic [7:0] CNF_SET_BLK  = 8'h01;
    localparam logic [7:0] CNF_SET_MST  = 8'hF1;
    localparam logic [7:0] CNF_CLR_ERA  = 8'hD0;

    localparam int SB_READY = 7;
    localparam int SB_ERAC  = 5;   // erase / clear failure
    localparam int SB_PRGS  = 4;   // write / set-lock failure
    localparam int SB_VPP   = 3;
    localparam int SB_LOCK  = 1;

    localparam logic [7:0] ERR_MASK = 8'b0011_1010;
    localparam logic [7:0] BAD_SEQ  = 8'b0011_0000;

    // Status bit that names the operation class of a failure.
    function automatic logic [7:0] class_bit(op_e op);
        logic [7:0] m;
        m = 8'h00;
        if (op == OP_CLR_ALL || op == OP_ERASE) m[SB_ERAC] = 1'b1;
        else if (op != OP_NONE)                 m[SB_PRGS] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/flk_guard.sv
// Protection check: maps a candidate operation and qualifiers to error bits.
// Purely combinational; zero result means the operation is permitted.
// Assumes the voltage fault takes priority over any lock fault.
module flk_guard
    import flk_pkg::*;
(
    input  op_e        op,
    input  logic       tgt_locked,
    input  logic       master,
    input  logic       vpp_ok,
    input  logic       rp_hh,
    output logic [7:0] err
);
    logic violation;

    // Decide whether the lock rules forbid the operation.
    always_comb begin
        unique case (op)
            OP_SET_BLK: violation = master && !rp_hh;
            OP_SET_MST: violation = !rp_hh;
            OP_CLR_ALL: violation = master && !rp_hh;
            OP_ERASE,
            OP_WRITE:   violation = tgt_locked && !rp_hh;
            default:    violation = 1'b0;
        endcase
    end

    // Compose the error byte from cause and operation class.
    always_comb begin
        err = 8'h00;
        if (op != OP_NONE) begin
            if (!vpp_ok) begin
                err = class_bit(op);
                err[SB_VPP] = 1'b1;
            end else if (violation) begin
                err = class_bit(op);
                err[SB_LOCK] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/flk_busy_timer.sv
// Busy-period model: a start pulse holds busy for BUSY_CYC cycles,
// with a done pulse in the last one. Assumes start never arrives while busy.
module flk_busy_timer #(
    parameter int BUSY_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(BUSY_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYC);

    logic [CNT_W-1:0] cnt_q;

    // Load on start, then count down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (start)           cnt_q <= LOAD;
        else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CNT_W'(1));

    assert_full_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt_q == LOAD));
    assert_no_restart_R13: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (cnt_q == '0));
endmodule

// File: rtl/flk_lock_store.sv
// Holds per-block lock flags and the master lock flag.
// Applies only permitted, completed operations; master lock has no clear path.
module flk_lock_store
    import flk_pkg::*;
#(
    parameter int NUM_BLK = 32,
    localparam int BLK_W = $clog2(NUM_BLK)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               apply_vld,
    input  op_e                apply_op,
    input  logic [BLK_W-1:0]   apply_blk,
    output logic [NUM_BLK-1:0] locks,
    output logic               master
);
    logic [NUM_BLK-1:0] lock_q;
    logic               mst_q;

    // Per-block flags: set one, or clear all in parallel.
    for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
        always_ff @(posedge clk) begin
            if (!rst_n)
                lock_q[g] <= 1'b0;
            else if (apply_vld && apply_op == OP_CLR_ALL)
                lock_q[g] <= 1'b0;
            else if (apply_vld && apply_op == OP_SET_BLK && apply_blk == BLK_W'(g))
                lock_q[g] <= 1'b1;
        end
    end

    // Master flag: set-only.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    mst_q <= 1'b0;
        else if (apply_vld && apply_op == OP_SET_MST)  mst_q <= 1'b1;
    end

    assign locks  = lock_q;
    assign master = mst_q;

    assert_master_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mst_q |=> mst_q);
    assert_clear_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (apply_vld && apply_op == OP_CLR_ALL) |=> (lock_q == '0));
    assert_locks_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !apply_vld |=> $stable(lock_q));
endmodule

// File: rtl/flk_cmd_seq.sv
// Command sequencer: tracks read mode and setup state, decodes confirm bytes,
// launches operations, and owns the sticky error bits of the status byte.
// Assumes the guard result refers to the candidate op and block of this cycle.
module flk_cmd_seq
    import flk_pkg::*;
#(
    parameter int NUM_BLK = 32,
    localparam int BLK_W = $clog2(NUM_BLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic [BLK_W-1:0] wr_blk,
    input  logic             busy,
    input  logic             done,
    input  logic [7:0]       guard_err,
    output op_e              cand_op,
    output logic             start,
    output logic             apply_vld,
    output op_e              apply_op,
    output logic [BLK_W-1:0] apply_blk,
    output logic [7:0]       err_bits,
    output logic             stat_mode
);
    mode_e            mode_q, mode_d;
    op_e              pend_op_q;
    logic [BLK_W-1:0] pend_blk_q;
    logic [7:0]       pend_err_q;
    logic [7:0]       err_q;
    logic             accept, bad_seq, clr_stat;

    assign accept = wr_en && !busy;

    // Decode the accepted byte against the current setup state.
    always_comb begin
        cand_op  = OP_NONE;
        bad_seq  = 1'b0;
        clr_stat = 1'b0;
        mode_d   = mode_q;
        if (accept) begin
            mode_d = MD_STATUS;
            unique case (mode_q)
                MD_LOCK_SU: begin
                    if      (wr_data == CNF_SET_BLK) cand_op = OP_SET_BLK;
                    else if (wr_data == CNF_SET_MST) cand_op = OP_SET_MST;
                    else if (wr_data == CNF_CLR_ERA) cand_op = OP_CLR_ALL;
                    else                             bad_seq = 1'b1;
                end
                MD_ERASE_SU: begin
                    if (wr_data == CNF_CLR_ERA) cand_op = OP_ERASE;
                    else                        bad_seq = 1'b1;
                end
                MD_WRITE_SU: cand_op = OP_WRITE;
                default: begin
                    if      (wr_data == CMD_RD_ARRAY) mode_d   = MD_ARRAY;
                    else if (wr_data == CMD_RD_STAT)  mode_d   = MD_STATUS;
                    else if (wr_data == CMD_CLR_STAT) clr_stat = 1'b1;
                    else if (wr_data == CMD_LOCK_SU)  mode_d   = MD_LOCK_SU;
                    else if (wr_data == CMD_ERASE_SU) mode_d   = MD_ERASE_SU;
                    else if (wr_data == CMD_WRITE_SU) mode_d   = MD_WRITE_SU;
                    else                              bad_seq  = 1'b1;
                end
            endcase
        end
    end

    assign start = (cand_op != OP_NONE);

    // Read mode and setup state register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MD_ARRAY;
        else        mode_q <= mode_d;
    end

    // Capture the launched operation and its verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_op_q  <= OP_NONE;
            pend_blk_q <= '0;
            pend_err_q <= 8'h00;
        end else if (start) begin
            pend_op_q  <= cand_op;
            pend_blk_q <= wr_blk;
            pend_err_q <= guard_err;
        end
    end

    // Sticky error bits: posted at completion or on a bad sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)        err_q <= 8'h00;
        else if (clr_stat) err_q <= 8'h00;
        else if (bad_seq)  err_q <= err_q | BAD_SEQ;
        else if (done)     err_q <= err_q | (pend_err_q & ERR_MASK);
    end

    assign apply_vld = done && (pend_err_q == 8'h00);
    assign apply_op  = pend_op_q;
    assign apply_blk = pend_blk_q;
    assign err_bits  = err_q;
    assign stat_mode = (mode_q != MD_ARRAY);

    assert_bad_no_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bad_seq |=> !busy);
    assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_stat |=> ((err_q & $past(err_q)) == $past(err_q)));
endmodule

// File: rtl/flk_lock_ctrl.sv
// Top of the lock-bit command controller: joins sequencer, guard,
// busy timer and lock store, and forms the read data and ready pin.
// Assumes one write per wr_en cycle and a synchronous active-low reset.
module flk_lock_ctrl
    import flk_pkg::*;
#(
    parameter int NUM_BLK  = 32,
    parameter int BUSY_CYC = 8,
    localparam int BLK_W = $clog2(NUM_BLK)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [BLK_W-1:0]   wr_blk,
    input  logic [7:0]         wr_data,
    input  logic               vpp_ok,
    input  logic               rp_hh,
    output logic [7:0]         rd_data,
    output logic               rdy,
    output logic [NUM_BLK-1:0] blk_lock,
    output logic               mst_lock
);
    op_e              cand_op, apply_op;
    logic             start, busy, done, apply_vld, stat_mode;
    logic [BLK_W-1:0] apply_blk;
    logic [7:0]       guard_err, err_bits;

    flk_cmd_seq #(.NUM_BLK(NUM_BLK)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_blk(wr_blk), .busy(busy), .done(done), .guard_err(guard_err),
        .cand_op(cand_op), .start(start), .apply_vld(apply_vld),
        .apply_op(apply_op), .apply_blk(apply_blk), .err_bits(err_bits),
        .stat_mode(stat_mode)
    );

    flk_guard u_guard (
        .op(cand_op), .tgt_locked(blk_lock[wr_blk]), .master(mst_lock),
        .vpp_ok(vpp_ok), .rp_hh(rp_hh), .err(guard_err)
    );

    flk_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done)
    );

    flk_lock_store #(.NUM_BLK(NUM_BLK)) u_store (
        .clk(clk), .rst_n(rst_n), .apply_vld(apply_vld), .apply_op(apply_op),
        .apply_blk(apply_blk), .locks(blk_lock), .master(mst_lock)
    );

    // Read mux: status byte in status mode, erased-array pattern otherwise.
    always_comb begin
        rd_data = 8'hFF;
        if (stat_mode) begin
            rd_data = err_bits & ERR_MASK;
            rd_data[SB_READY] = !busy;
        end
    end

    assign rdy = !busy;
endmodule

// File: tb/sim_flk_lock_ctrl.sv
module sim_flk_lock_ctrl;
    localparam int NB = 32;
    localparam int BC = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [4:0]    wr_blk = '0;
    logic [7:0]    wr_data = '0;
    logic          vpp_ok = 1'b1;
    logic          rp_hh = 1'b0;
    logic [7:0]    rd_data;
    logic          rdy;
    logic [NB-1:0] blk_lock;
    logic          mst_lock;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    flk_lock_ctrl #(.NUM_BLK(NB), .BUSY_CYC(BC)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_blk(wr_blk),
        .wr_data(wr_data), .vpp_ok(vpp_ok), .rp_hh(rp_hh), .rd_data(rd_data),
        .rdy(rdy), .blk_lock(blk_lock), .mst_lock(mst_lock)
    );

    typedef struct packed {
        logic [7:0]  c1;
        logic [7:0]  c2;
        logic [4:0]  blk;
        logic        vpp;
        logic        rp;
        logic [7:0]  sr;
        logic        mst;
        logic [31:0] locks;
        logic        busy;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VT [NV] = '{
        '{8'h60, 8'h01, 5'd3, 1'b1, 1'b0, 8'h80, 1'b0, 32'h0000_0008, 1'b1}, // R8 set blk3
        '{8'h40, 8'hAA, 5'd3, 1'b1, 1'b0, 8'h92, 1'b0, 32'h0000_0008, 1'b1}, // R10 write locked
        '{8'h40, 8'hAA, 5'd3, 1'b1, 1'b1, 8'h80, 1'b0, 32'h0000_0008, 1'b1}, // R10 override
        '{8'h20, 8'hD0, 5'd3, 1'b0, 1'b1, 8'hA8, 1'b0, 32'h0000_0008, 1'b1}, // R6 erase no vpp
        '{8'h20, 8'hD0, 5'd4, 1'b1, 1'b0, 8'h80, 1'b0, 32'h0000_0008, 1'b1}, // R10 unlocked erase
        '{8'h60, 8'hD0, 5'd0, 1'b0, 1'b0, 8'hA8, 1'b0, 32'h0000_0008, 1'b1}, // R6 clear no vpp
        '{8'h60, 8'h33, 5'd3, 1'b1, 1'b0, 8'hB0, 1'b0, 32'h0000_0008, 1'b0}, // R5 bad confirm
        '{8'h60, 8'hF1, 5'd0, 1'b1, 1'b0, 8'h92, 1'b0, 32'h0000_0008, 1'b1}, // R9 master no rp
        '{8'h60, 8'hF1, 5'd0, 1'b1, 1'b1, 8'h80, 1'b1, 32'h0000_0008, 1'b1}, // R9 master set
        '{8'h60, 8'h01, 5'd5, 1'b1, 1'b0, 8'h92, 1'b1, 32'h0000_0008, 1'b1}, // R8 refused
        '{8'h60, 8'h01, 5'd5, 1'b1, 1'b1, 8'h80, 1'b1, 32'h0000_0028, 1'b1}, // R8 override
        '{8'h60, 8'hD0, 5'd3, 1'b1, 1'b0, 8'hA2, 1'b1, 32'h0000_0028, 1'b1}, // R7 clear refused
        '{8'h60, 8'hD0, 5'd3, 1'b1, 1'b1, 8'h80, 1'b1, 32'h0000_0000, 1'b1}, // R7 R4 R11 clear ok
        '{8'h20, 8'hD0, 5'd5, 1'b1, 1'b0, 8'h80, 1'b1, 32'h0000_0000, 1'b1}, // R4 blk5 now free
        '{8'h60, 8'h01, 5'd7, 1'b0, 1'b1, 8'h98, 1'b1, 32'h0000_0000, 1'b1}  // R6 set no vpp
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d, input logic [4:0] b);
        wr_en = 1'b1; wr_data = d; wr_blk = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!rdy && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int nb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rd_data", 32'(rd_data), 32'hFF);
        check("R1 rdy", 32'(rdy), 32'h1);
        check("R1 locks", blk_lock, 32'h0);
        check("R1 master", 32'(mst_lock), 32'h0);
        // R2 mode switching
        send(8'h70, 5'd0);
        check("R2 status mode", 32'(rd_data), 32'h80);
        send(8'hFF, 5'd0);
        check("R2 array mode", 32'(rd_data), 32'hFF);

        for (int i = 0; i < NV; i++) begin
            vpp_ok = VT[i].vpp;
            rp_hh  = VT[i].rp;
            send(VT[i].c1, VT[i].blk);
            send(VT[i].c2, VT[i].blk);
            wait_ready(nb);
            check($sformatf("R3 busy len vec%0d", i), 32'(nb), VT[i].busy ? BC : 0);
            check($sformatf("R6-class status vec%0d", i), 32'(rd_data), 32'(VT[i].sr));
            check($sformatf("R4 locks vec%0d", i), blk_lock, VT[i].locks);
            check($sformatf("R11 master vec%0d", i), 32'(mst_lock), 32'(VT[i].mst));
            send(8'h50, 5'd0);
            check($sformatf("R12 clear vec%0d", i), 32'(rd_data), 32'h80);
        end

        // R12 sticky across other commands
        vpp_ok = 1'b1; rp_hh = 1'b0;
        send(8'h60, 5'd9); send(8'h01, 5'd9);
        wait_ready(nb);
        send(8'h70, 5'd0);
        check("R12 sticky after 70", 32'(rd_data), 32'h92);
        send(8'hFF, 5'd0); send(8'h70, 5'd0);
        check("R12 sticky after FF", 32'(rd_data), 32'h92);
        send(8'h50, 5'd0);
        check("R12 cleared", 32'(rd_data), 32'h80);
        // R5 unknown first byte
        send(8'h33, 5'd0);
        check("R5 unknown cmd status", 32'(rd_data), 32'hB0);
        check("R5 unknown cmd no busy", 32'(rdy), 32'h1);
        send(8'h50, 5'd0);
        // R13 writes during busy ignored; R3 ready bit low while busy
        rp_hh = 1'b1;
        send(8'h60, 5'd9); send(8'h01, 5'd9);
        check("R3 busy status", 32'(rd_data), 32'h00);
        check("R3 rdy low", 32'(rdy), 32'h0);
        send(8'h60, 5'd9); send(8'hD0, 5'd9);
        wait_ready(nb);
        check("R13 busy len", 32'(nb), BC - 2);
        check("R13 locks", blk_lock, 32'h0000_0200);
        check("R13 status", 32'(rd_data), 32'h80);
        send(8'h70, 5'd0);
        check("R13 still status mode", 32'(rd_data), 32'h80);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule